// File: doc/BRIEF.md
# State-Enable Access Permission Checker

This block decides, in a single combinational step, whether an instruction that touches a guarded piece of extension state may go ahead. It takes the current privilege mode, a description of what is being touched, and the live contents of the machine, hypervisor and supervisor enable registers held in the CSR bank. It answers with exactly one of three outcomes: allow, raise an illegal-instruction trap, or raise a virtual-instruction trap.

A register at one privilege level restricts only the modes below it. The checker looks at the levels in a fixed order: machine first, then hypervisor for virtualized modes, then supervisor for user-level modes. The first level that denies the access decides which trap is raised. The same logic also guards accesses to the lower-level enable registers themselves, using the top bit of each register. Floating-point instructions on a hart without hardware floating-point registers are gated by the control/status enable bit. Instruction decode and trap entry sit outside this block.

Top module: `stateen_access_check`

## Requirements
- R1: Privilege is encoded as 0 = machine, 1 = supervisor/hypervisor-host, 2 = user, 3 = virtual supervisor, 4 = virtual user. Any access made in machine mode is allowed, whatever the enable registers hold.
- R2: In supervisor mode (1), an access is allowed when the guarding machine bit is set. Otherwise it raises an illegal-instruction trap.
- R3: In user mode (2), the guarding bit must be set in both the machine and the supervisor register. A clear bit at either level raises an illegal-instruction trap. The hypervisor register is not consulted.
- R4: In virtual supervisor mode (3), a clear machine bit raises an illegal-instruction trap even when the hypervisor bit is also clear. A set machine bit with a clear hypervisor bit raises a virtual-instruction trap. The supervisor register is not consulted.
- R5: In virtual user mode (4), the levels are checked in the order machine, hypervisor, supervisor. A machine denial raises illegal, a hypervisor denial raises virtual, and a supervisor denial raises illegal.
- R6: For a resource access (kind 0), the guarding bit is bit `res_bit_i` of register `reg_idx_i` in each level. Every other bit of the enable vectors has no effect.
- R7: An access to supervisor enable register `reg_idx_i` (kind 2) is gated by bit XLEN-1 of machine register `reg_idx_i`. From modes 3 and 4 it is also gated by bit XLEN-1 of hypervisor register `reg_idx_i`, and a denial there raises a virtual-instruction trap. The supervisor registers' own contents do not matter for this kind.
- R8: An access to hypervisor enable register `reg_idx_i` (kind 1) is gated only by bit XLEN-1 of machine register `reg_idx_i`. The hypervisor and supervisor contents have no effect, and this kind never raises a virtual-instruction trap.
- R9: For a floating-point instruction (kind 3), the access is always allowed when `fp_regs_present_i` is 1. When it is 0, the instruction is gated exactly as a resource access to bit 1 of register 0.
- R10: Exactly one of `allow_o`, `illegal_o` and `virtual_o` is high for every legal input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| priv_i | input | 3 | Current privilege mode (encoding in R1) |
| kind_i | input | 2 | Access kind: 0 resource, 1 hypervisor enable register, 2 supervisor enable register, 3 floating-point instruction |
| reg_idx_i | input | $clog2(NREG) | Index of the enable register involved |
| res_bit_i | input | $clog2(XLEN) | Guard bit position for a resource access |
| fp_regs_present_i | input | 1 | Hart has dedicated floating-point registers |
| m_en_i | input | NREG*XLEN | Machine enable registers, register k at bits [k*XLEN +: XLEN] |
| h_en_i | input | NREG*XLEN | Hypervisor enable registers, same layout |
| s_en_i | input | NREG*XLEN | Supervisor enable registers, same layout |
| allow_o | output | 1 | Access may proceed |
| illegal_o | output | 1 | Raise illegal-instruction trap |
| virtual_o | output | 1 | Raise virtual-instruction trap |

## Verification
The bench builds the block with its defaults: XLEN of 64 and four registers per level. With these values, bit 63 acts as the register-access gate and register index 3 is the last slot, so both edges of the flattened bit selection are exercised. Each table entry sets only the guarding bit. It can also fill every other bit with the opposite value, which shows that neighbouring bits and other registers are never selected by mistake.

// File: rtl/stateen_pkg.sv
package stateen_pkg;

  typedef enum logic [2:0] {
    PRV_M  = 3'd0,
    PRV_S  = 3'd1,
    PRV_U  = 3'd2,
    PRV_VS = 3'd3,
    PRV_VU = 3'd4
  } priv_e;

  typedef enum logic [1:0] {
    ACC_RES  = 2'd0,
    ACC_HREG = 2'd1,
    ACC_SREG = 2'd2,
    ACC_FP   = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    VERD_ALLOW   = 2'd0,
    VERD_ILLEGAL = 2'd1,
    VERD_VIRTUAL = 2'd2
  } verdict_e;

  // Level indices used for the per-level bit pickers
  localparam int LVL_M   = 0;
  localparam int LVL_H   = 1;
  localparam int LVL_S   = 2;
  localparam int NLEVELS = 3;

  // The control/status enable bit sits in register 0, bit 1
  localparam int FP_GATE_REG = 0;
  localparam int FP_GATE_BIT = 1;

  function automatic logic mode_is_virtual(input logic [2:0] p);
    return (p == PRV_VS) || (p == PRV_VU);
  endfunction

  function automatic logic mode_is_user(input logic [2:0] p);
    return (p == PRV_U) || (p == PRV_VU);
  endfunction

  function automatic logic mode_is_machine(input logic [2:0] p);
    return p == PRV_M;
  endfunction

endpackage

// File: rtl/stateen_target_decode.sv
module stateen_target_decode
  import stateen_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NREG = 4,
  localparam int BIT_W = $clog2(XLEN),
  localparam int REG_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [1:0]       kind_i,
  input  logic [REG_W-1:0] reg_idx_i,
  input  logic [BIT_W-1:0] res_bit_i,
  input  logic             fp_regs_present_i,
  output logic [REG_W-1:0] tgt_reg_o,
  output logic [BIT_W-1:0] tgt_bit_o,
  output logic             h_gate_o,   // hypervisor level applies to this kind
  output logic             s_gate_o,   // supervisor level applies to this kind
  output logic             bypass_o    // kind is never gated
);

  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(XLEN - 1);

  always_comb begin
    tgt_reg_o = reg_idx_i;
    tgt_bit_o = res_bit_i;
    h_gate_o  = 1'b1;
    s_gate_o  = 1'b1;
    bypass_o  = 1'b0;
    unique case (acc_e'(kind_i))
      ACC_RES: begin
        // defaults already describe a plain resource access
      end
      ACC_HREG: begin
        tgt_bit_o = TOP_BIT;
        h_gate_o  = 1'b0;
        s_gate_o  = 1'b0;
      end
      ACC_SREG: begin
        tgt_bit_o = TOP_BIT;
        s_gate_o  = 1'b0;
      end
      ACC_FP: begin
        tgt_reg_o = REG_W'(FP_GATE_REG);
        tgt_bit_o = BIT_W'(FP_GATE_BIT);
        bypass_o  = fp_regs_present_i;
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/stateen_bit_pick.sv
module stateen_bit_pick #(
  parameter int XLEN = 64,
  parameter int NREG = 4,
  localparam int BIT_W = $clog2(XLEN),
  localparam int REG_W = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int TOTAL = NREG * XLEN
) (
  input  logic [TOTAL-1:0] vec_i,
  input  logic [REG_W-1:0] reg_i,
  input  logic [BIT_W-1:0] bit_i,
  output logic             bit_o
);

  logic [XLEN-1:0] regs [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_split
    assign regs[k] = vec_i[k*XLEN +: XLEN];
  end

  always_comb begin
    bit_o = 1'b0;
    if (int'(reg_i) < NREG) begin
      bit_o = regs[reg_i][bit_i];
    end
  end

endmodule

// File: rtl/stateen_level_walk.sv
module stateen_level_walk
  import stateen_pkg::*;
(
  input  logic [2:0] priv_i,
  input  logic       m_ok_i,
  input  logic       h_ok_i,
  input  logic       s_ok_i,
  input  logic       h_gate_i,
  input  logic       s_gate_i,
  input  logic       bypass_i,
  output logic [1:0] verdict_o,
  output logic       m_deny_o,
  output logic       h_deny_o,
  output logic       s_deny_o
);

  logic m_applies;
  logic h_applies;
  logic s_applies;

  assign m_applies = !bypass_i && !mode_is_machine(priv_i);
  assign h_applies = !bypass_i && mode_is_virtual(priv_i) && h_gate_i;
  assign s_applies = !bypass_i && mode_is_user(priv_i) && s_gate_i;

  // Ordered walk: the first level that denies decides the trap
  assign m_deny_o = m_applies && !m_ok_i;
  assign h_deny_o = !m_deny_o && h_applies && !h_ok_i;
  assign s_deny_o = !m_deny_o && !h_deny_o && s_applies && !s_ok_i;

  always_comb begin
    if (m_deny_o)      verdict_o = VERD_ILLEGAL;
    else if (h_deny_o) verdict_o = VERD_VIRTUAL;
    else if (s_deny_o) verdict_o = VERD_ILLEGAL;
    else               verdict_o = VERD_ALLOW;
  end

  always_comb begin
    if (!$isunknown({priv_i, m_ok_i, h_ok_i, s_ok_i, h_gate_i, s_gate_i, bypass_i})) begin
      // R4 R5: a virtual trap needs a virtualized mode that passed the machine level
      p_virtual_needs_m_pass_r5: assert (verdict_o != VERD_VIRTUAL ||
                                         (mode_is_virtual(priv_i) && m_ok_i))
        else $error("virtual verdict without machine pass");
      // R3: plain user mode never sees a hypervisor denial
      p_user_no_hyp_r3: assert (priv_i != PRV_U || !h_deny_o)
        else $error("hypervisor level consulted in user mode");
      // Levels deny in strict order
      p_single_deny_r5: assert ($countones({m_deny_o, h_deny_o, s_deny_o}) <= 1)
        else $error("more than one level reported denial");
    end
  end

endmodule

// File: rtl/stateen_access_check.sv
module stateen_access_check
  import stateen_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NREG = 4,
  localparam int BIT_W = $clog2(XLEN),
  localparam int REG_W = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int TOTAL = NREG * XLEN
) (
  input  logic [2:0]       priv_i,
  input  logic [1:0]       kind_i,
  input  logic [REG_W-1:0] reg_idx_i,
  input  logic [BIT_W-1:0] res_bit_i,
  input  logic             fp_regs_present_i,
  input  logic [TOTAL-1:0] m_en_i,
  input  logic [TOTAL-1:0] h_en_i,
  input  logic [TOTAL-1:0] s_en_i,
  output logic             allow_o,
  output logic             illegal_o,
  output logic             virtual_o
);

  logic [REG_W-1:0] tgt_reg;
  logic [BIT_W-1:0] tgt_bit;
  logic             h_gate;
  logic             s_gate;
  logic             bypass;

  stateen_target_decode #(.XLEN(XLEN), .NREG(NREG)) u_decode (
    .kind_i            (kind_i),
    .reg_idx_i         (reg_idx_i),
    .res_bit_i         (res_bit_i),
    .fp_regs_present_i (fp_regs_present_i),
    .tgt_reg_o         (tgt_reg),
    .tgt_bit_o         (tgt_bit),
    .h_gate_o          (h_gate),
    .s_gate_o          (s_gate),
    .bypass_o          (bypass)
  );

  logic [TOTAL-1:0] lvl_vec [NLEVELS];
  logic [NLEVELS-1:0] lvl_ok;

  assign lvl_vec[LVL_M] = m_en_i;
  assign lvl_vec[LVL_H] = h_en_i;
  assign lvl_vec[LVL_S] = s_en_i;

  for (genvar l = 0; l < NLEVELS; l++) begin : g_level
    stateen_bit_pick #(.XLEN(XLEN), .NREG(NREG)) u_pick (
      .vec_i (lvl_vec[l]),
      .reg_i (tgt_reg),
      .bit_i (tgt_bit),
      .bit_o (lvl_ok[l])
    );
  end

  logic [1:0] verdict;
  logic       m_deny;
  logic       h_deny;
  logic       s_deny;

  stateen_level_walk u_walk (
    .priv_i    (priv_i),
    .m_ok_i    (lvl_ok[LVL_M]),
    .h_ok_i    (lvl_ok[LVL_H]),
    .s_ok_i    (lvl_ok[LVL_S]),
    .h_gate_i  (h_gate),
    .s_gate_i  (s_gate),
    .bypass_i  (bypass),
    .verdict_o (verdict),
    .m_deny_o  (m_deny),
    .h_deny_o  (h_deny),
    .s_deny_o  (s_deny)
  );

  assign allow_o   = verdict == VERD_ALLOW;
  assign illegal_o = verdict == VERD_ILLEGAL;
  assign virtual_o = verdict == VERD_VIRTUAL;

  always_comb begin
    if (!$isunknown({priv_i, kind_i, reg_idx_i, res_bit_i, fp_regs_present_i,
                     m_en_i, h_en_i, s_en_i})) begin
      p_onehot_out_r10: assert ($countones({allow_o, illegal_o, virtual_o}) == 1)
        else $error("outputs not one-hot");
      p_machine_allowed_r1: assert (priv_i != PRV_M || allow_o)
        else $error("machine mode access blocked");
      p_hreg_never_virtual_r8: assert (kind_i != ACC_HREG || !virtual_o)
        else $error("hypervisor register access gave virtual trap");
      p_fp_bypass_r9: assert (!(kind_i == ACC_FP && fp_regs_present_i) || allow_o)
        else $error("floating-point access gated with registers present");
      p_deny_blocks_allow_r2: assert (!(m_deny || h_deny || s_deny) || !allow_o)
        else $error("denial reported while allowed");
    end
  end

endmodule

// File: tb/stateen_access_check_tb.sv
module stateen_access_check_tb;

  localparam int XLEN  = 64;
  localparam int NREG  = 4;
  localparam int BIT_W = $clog2(XLEN);
  localparam int REG_W = $clog2(NREG);
  localparam int TOTAL = NREG * XLEN;

  // outcome codes used by the bench: 0 allow, 1 illegal, 2 virtual
  localparam logic [1:0] A = 2'd0;
  localparam logic [1:0] I = 2'd1;
  localparam logic [1:0] V = 2'd2;

  typedef struct packed {
    logic [2:0] priv;
    logic [1:0] kind;
    logic [1:0] ridx;
    logic [5:0] bitn;
    logic       fpp;
    logic       mb;
    logic       hb;
    logic       sb;
    logic       inv;
    logic [1:0] exp;
  } vec_t;

  localparam int NVEC = 28;
  // priv kind reg bit fpp m h s inv expected
  localparam vec_t VEC [NVEC] = '{
    '{3'd0, 2'd0, 2'd0, 6'd5,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, A}, // R1
    '{3'd0, 2'd1, 2'd3, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, A}, // R1
    '{3'd1, 2'd0, 2'd1, 6'd10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, A}, // R2
    '{3'd1, 2'd0, 2'd1, 6'd10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, I}, // R2 R6
    '{3'd2, 2'd0, 2'd2, 6'd7,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, A}, // R3
    '{3'd2, 2'd0, 2'd2, 6'd7,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, I}, // R3
    '{3'd2, 2'd0, 2'd2, 6'd7,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, I}, // R3
    '{3'd3, 2'd0, 2'd0, 6'd3,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, A}, // R4
    '{3'd3, 2'd0, 2'd0, 6'd3,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, V}, // R4
    '{3'd3, 2'd0, 2'd0, 6'd3,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, I}, // R4
    '{3'd4, 2'd0, 2'd1, 6'd20, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, A}, // R5
    '{3'd4, 2'd0, 2'd1, 6'd20, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, I}, // R5
    '{3'd4, 2'd0, 2'd1, 6'd20, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, V}, // R5
    '{3'd4, 2'd0, 2'd1, 6'd20, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, I}, // R5
    '{3'd1, 2'd2, 2'd1, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, A}, // R7
    '{3'd3, 2'd2, 2'd1, 6'd0,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, V}, // R7
    '{3'd3, 2'd2, 2'd1, 6'd0,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, A}, // R7
    '{3'd4, 2'd2, 2'd2, 6'd0,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, I}, // R7
    '{3'd1, 2'd1, 2'd3, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, A}, // R8
    '{3'd1, 2'd1, 2'd3, 6'd0,  1'b0, 1'b0, 1'b1, 1'b1, 1'b1, I}, // R8
    '{3'd3, 2'd1, 2'd0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, A}, // R8
    '{3'd2, 2'd3, 2'd2, 6'd9,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, A}, // R9
    '{3'd2, 2'd3, 2'd2, 6'd9,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, A}, // R9
    '{3'd2, 2'd3, 2'd2, 6'd9,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, I}, // R9
    '{3'd3, 2'd3, 2'd0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, V}, // R9
    '{3'd1, 2'd0, 2'd3, 6'd63, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, A}, // R6
    '{3'd1, 2'd0, 2'd0, 6'd0,  1'b0, 1'b0, 1'b1, 1'b1, 1'b1, I}, // R6
    '{3'd2, 2'd0, 2'd2, 6'd33, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, A}  // R6
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0]       priv;
  logic [1:0]       kind;
  logic [REG_W-1:0] ridx;
  logic [BIT_W-1:0] rbit;
  logic             fpp;
  logic [TOTAL-1:0] m_en;
  logic [TOTAL-1:0] h_en;
  logic [TOTAL-1:0] s_en;
  logic             allow;
  logic             illegal;
  logic             virt;

  stateen_access_check #(.XLEN(XLEN), .NREG(NREG)) u_dut (
    .priv_i            (priv),
    .kind_i            (kind),
    .reg_idx_i         (ridx),
    .res_bit_i         (rbit),
    .fp_regs_present_i (fpp),
    .m_en_i            (m_en),
    .h_en_i            (h_en),
    .s_en_i            (s_en),
    .allow_o           (allow),
    .illegal_o         (illegal),
    .virtual_o         (virt)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  function automatic logic [1:0] observed();
    if (allow && !illegal && !virt) return A;
    if (illegal && !allow && !virt) return I;
    if (virt && !allow && !illegal) return V;
    return 2'd3;
  endfunction

  // Position of the guarding bit, restated from the requirements
  function automatic int guard_pos(input vec_t v);
    case (v.kind)
      2'd0:    return int'(v.ridx) * XLEN + int'(v.bitn);
      2'd3:    return 1;
      default: return int'(v.ridx) * XLEN + (XLEN - 1);
    endcase
  endfunction

  task automatic check(input string req, input int idx, input logic [1:0] exp);
    logic [1:0] got;
    got = observed();
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s case %0d: actual %0d expected %0d", req, idx, got, exp);
    end
  endtask

  task automatic check_onehot(input int idx);
    n_checks++;
    if ($countones({allow, illegal, virt}) != 1) begin
      n_fail++;
      $display("FAIL R10 case %0d: actual %b%b%b expected one-hot", idx, allow, illegal, virt);
    end
  endtask

  task automatic apply(input vec_t v);
    int p;
    @(negedge clk);
    p    = guard_pos(v);
    priv = v.priv;
    kind = v.kind;
    ridx = v.ridx;
    rbit = v.bitn;
    fpp  = v.fpp;
    m_en = v.inv ? '1 : '0;
    h_en = v.inv ? '1 : '0;
    s_en = v.inv ? '1 : '0;
    m_en[p] = v.mb;
    h_en[p] = v.hb;
    s_en[p] = v.sb;
    @(posedge clk);
    #1;
  endtask

  initial begin
    priv = 3'd2; kind = 2'd0; ridx = '0; rbit = '0; fpp = 1'b0;
    m_en = '0; h_en = '0; s_en = '0;
    @(posedge clk);
    #1;
    // Cleared enables: user access denied (R3), outputs one-hot (R10)
    check("R3", -1, I);
    check_onehot(-1);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i]);
      check("vector", i, VEC[i].exp);
      check_onehot(i);
    end

    // R1 R2 R3 R4 R5: every mode with all enables cleared
    for (int p = 0; p < 5; p++) begin
      @(negedge clk);
      priv = 3'(p); kind = 2'd0; ridx = 2'd2; rbit = 6'd40; fpp = 1'b0;
      m_en = '0; h_en = '0; s_en = '0;
      @(posedge clk);
      #1;
      check(p == 0 ? "R1" : "R2", 100 + p, p == 0 ? A : I);
    end

    // R1: machine mode with every enable set stays allowed
    @(negedge clk);
    priv = 3'd0; kind = 2'd2; m_en = '1; h_en = '1; s_en = '1;
    @(posedge clk);
    #1;
    check("R1", 200, A);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule